// File: doc/BRIEF.md
# Retrying Bus Command Sequencer

This block sits between an address-translation stage and the bus. It takes one request at a time from upstream and presents it downstream as a single command. The command has one address field, a one-bit flag saying whether that address is virtual or physical, a write enable, byte selects and write data. The command carries no strobe and no address-space identifier.

The slave answers with one of three codes: ack, retry or error. On a retry the sequencer drops the command for a backoff period and then presents the same command again. The length of that period is drawn from a free-running pseudo-random generator, from 1 to 32 cycles. A random wait makes it less likely that two masters which collided once will collide again in lockstep. A build parameter swaps in a fixed 32-cycle wait so the two behaviours can be compared. An ack or an error ends the transaction and is reported upstream as a one-cycle pulse. A retry is never reported upstream.

Top module: `retry_master`

## Requirements
- R1: After a reset cycle (rst_n low at a clock edge), `up_rdy` is 1 and `cmd_vld` and `up_done` are 0.
- R2: A request is accepted only at an edge where `up_rdy` is 1 and `up_req` is 1. `up_rdy` stays 0 from the edge after acceptance until the transaction ends, so at most one transaction is outstanding.
- R3: `cmd_adr`, `cmd_virt`, `cmd_we` and `cmd_wdat` take the upstream values captured at acceptance. They do not change until the next acceptance, whatever the upstream inputs do in the meantime.
- R4: `cmd_sel` holds the captured byte selects through every backoff wait and every reissue. A retry never clears it.
- R5: `cmd_vld` is 1 from the cycle after acceptance until the edge at which `rsp_vld` is sampled high. The response codes are: 2'b00 ack, 2'b01 retry, 2'b10 error. The code 2'b11 is treated as an error.
- R6: A retry response drops `cmd_vld` for exactly N cycles, where N is the wait drawn at that edge, and then raises it again with the same command. A retry produces no `up_done` pulse.
- R7: In random mode, N = (low 5 bits of the generator state at the retry edge) + 1, so 1 <= N <= 32.
- R8: The generator is a 16-bit shift register. It is loaded with 16'hACE1 at reset and advances on every clock edge while out of reset. It shifts left, and the new bit 0 is the XOR of bits 15, 13, 12 and 10. It never holds zero.
- R9: With `FIXED_WAIT` set to 1, every retry wait is exactly 32 cycles.
- R10: An ack or error sampled while the command is presented makes `up_done` 1 for exactly one cycle, in the cycle after that edge. In that cycle `up_err` is 1 for an error code and 0 for ack, and `up_rdat` shows the `rsp_rdat` sampled with the response.
- R11: A `rsp_vld` sampled while `cmd_vld` is 0, in idle or during a backoff, has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| up_req | input | 1 | Upstream request |
| up_rdy | output | 1 | Sequencer idle; a request will be taken |
| up_adr | input | ADDR_W | Request address |
| up_virt | input | 1 | 1 = address is virtual, 0 = physical |
| up_we | input | 1 | Write enable |
| up_sel | input | SEL_W | Byte selects |
| up_wdat | input | DATA_W | Write data |
| up_done | output | 1 | One-cycle completion pulse |
| up_err | output | 1 | Completion was an error |
| up_rdat | output | DATA_W | Read data of the completion |
| cmd_vld | output | 1 | Command presented downstream |
| cmd_adr | output | ADDR_W | Command address |
| cmd_virt | output | 1 | Command virtual/physical flag |
| cmd_we | output | 1 | Command write enable |
| cmd_sel | output | SEL_W | Command byte selects |
| cmd_wdat | output | DATA_W | Command write data |
| rsp_vld | input | 1 | Slave response valid |
| rsp_code | input | 2 | Response code |
| rsp_rdat | input | DATA_W | Response read data |

## Verification
The bench keeps upstream requests asserted with changing fields for a whole transaction. A design that latched the fields late, or that accepted a second request while busy, would show a changed command or an extra completion. It sends stray responses during idle and during backoff waits, which would end a transaction early or give a spurious pulse in a design that did not gate responses. It measures each gap in `cmd_vld` against the expected draw from the generator and against the fixed 32-cycle mode. This catches off-by-one waits, a generator stuck on one value, and selects that are cleared during the wait. Error codes 2'b10 and 2'b11 must both give `up_err`, and a design that decoded only one of them would report an ack instead.

// File: rtl/rtry_pkg.sv
// Shared types for the retrying bus command sequencer.
// Assumes a two-bit response code on the downstream response channel.
package rtry_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'b00,
        SEQ_ISSUE   = 2'b01,
        SEQ_BACKOFF = 2'b10
    } seq_state_t;

    localparam logic [1:0] RSP_ACK   = 2'b00;
    localparam logic [1:0] RSP_RETRY = 2'b01;
    localparam logic [1:0] RSP_ERROR = 2'b10;

    // True for any code that ends a transaction with an error
    function automatic logic code_is_error(input logic [1:0] code);
        return (code != RSP_ACK) && (code != RSP_RETRY);
    endfunction

endpackage

// File: rtl/backoff_lfsr.sv
// Free-running Fibonacci shift register for backoff draws.
// Shifts left; the new bit 0 is the parity of the state under TAP_MASK.
// Assumes SEED is nonzero and TAP_MASK is primitive, so zero is never reached.
module backoff_lfsr #(
    parameter int             LFSR_W   = 16,
    parameter logic [LFSR_W-1:0] SEED     = 16'hACE1,
    parameter logic [LFSR_W-1:0] TAP_MASK = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [LFSR_W-1:0] state
);

    logic [LFSR_W-1:0] state_q;
    logic              feedback;

    // Feedback bit from the tapped positions
    always_comb feedback = ^(state_q & TAP_MASK);

    // Advance every cycle out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= {state_q[LFSR_W-2:0], feedback};
    end

    assign state = state_q;

endmodule

// File: rtl/backoff_timer.sv
// Down-counter that times one backoff wait.
// A load of N makes expire high in the Nth cycle after the load edge.
// Assumes load_val is at least 1.
module backoff_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    // Load on a retry, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    // Last cycle of the wait
    always_comb expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/req_hold.sv
// Holding register for the command fields of the outstanding transaction.
// Captures on the accept strobe and holds until the next one, so the
// fields (byte selects included) survive every retry unchanged.
module req_hold #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SEL_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] in_adr,
    input  logic              in_virt,
    input  logic              in_we,
    input  logic [SEL_W-1:0]  in_sel,
    input  logic [DATA_W-1:0] in_wdat,
    output logic [ADDR_W-1:0] out_adr,
    output logic              out_virt,
    output logic              out_we,
    output logic [SEL_W-1:0]  out_sel,
    output logic [DATA_W-1:0] out_wdat
);

    // Capture the request fields at acceptance only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_adr  <= '0;
            out_virt <= 1'b0;
            out_we   <= 1'b0;
            out_sel  <= '0;
            out_wdat <= '0;
        end else if (capture) begin
            out_adr  <= in_adr;
            out_virt <= in_virt;
            out_we   <= in_we;
            out_sel  <= in_sel;
            out_wdat <= in_wdat;
        end
    end

endmodule

// File: rtl/retry_master.sv
// Bus-master command sequencer with randomized retry backoff.
// Takes one upstream request at a time and presents it as a command
// until the slave answers. A retry waits 1..2**WAIT_BITS cycles (random) or
// exactly 2**WAIT_BITS cycles (FIXED_WAIT=1) and then reissues the command.
// Assumes the slave responds only while cmd_vld is high; other responses
// are ignored.
module retry_master
    import rtry_pkg::*;
#(
    parameter int             ADDR_W     = 32,
    parameter int             DATA_W     = 32,
    parameter int             SEL_W      = DATA_W / 8,
    parameter int             WAIT_BITS  = 5,
    parameter int             LFSR_W     = 16,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter bit             FIXED_WAIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    output logic              up_rdy,
    input  logic [ADDR_W-1:0] up_adr,
    input  logic              up_virt,
    input  logic              up_we,
    input  logic [SEL_W-1:0]  up_sel,
    input  logic [DATA_W-1:0] up_wdat,
    output logic              up_done,
    output logic              up_err,
    output logic [DATA_W-1:0] up_rdat,
    output logic              cmd_vld,
    output logic [ADDR_W-1:0] cmd_adr,
    output logic              cmd_virt,
    output logic              cmd_we,
    output logic [SEL_W-1:0]  cmd_sel,
    output logic [DATA_W-1:0] cmd_wdat,
    input  logic              rsp_vld,
    input  logic [1:0]        rsp_code,
    input  logic [DATA_W-1:0] rsp_rdat
);

    localparam int MAX_WAIT = 1 << WAIT_BITS;
    localparam int CNT_W    = WAIT_BITS + 1;

    seq_state_t        st_q, st_nxt;
    logic              capture;
    logic              wait_load;
    logic              finish;
    logic              wait_expire;
    logic [CNT_W-1:0]  wait_val;
    logic [LFSR_W-1:0] lfsr_val;
    logic              done_q, err_q;
    logic [DATA_W-1:0] rdat_q;

    backoff_lfsr #(
        .LFSR_W   (LFSR_W),
        .SEED     (LFSR_SEED),
        .TAP_MASK (LFSR_TAPS)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .state (lfsr_val)
    );

    // Wait length: fixed maximum or a draw from the generator's low bits
    generate
        if (FIXED_WAIT) begin : g_fixed_wait
            assign wait_val = CNT_W'(MAX_WAIT);
        end else begin : g_random_wait
            assign wait_val = {1'b0, lfsr_val[WAIT_BITS-1:0]} + CNT_W'(1);
        end
    endgenerate

    backoff_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load),
        .load_val (wait_val),
        .expire   (wait_expire)
    );

    req_hold #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .in_adr   (up_adr),
        .in_virt  (up_virt),
        .in_we    (up_we),
        .in_sel   (up_sel),
        .in_wdat  (up_wdat),
        .out_adr  (cmd_adr),
        .out_virt (cmd_virt),
        .out_we   (cmd_we),
        .out_sel  (cmd_sel),
        .out_wdat (cmd_wdat)
    );

    // Sequencer next-state and strobe decode
    always_comb begin
        st_nxt    = st_q;
        capture   = 1'b0;
        wait_load = 1'b0;
        finish    = 1'b0;
        unique case (st_q)
            SEQ_IDLE: begin
                if (up_req) begin
                    capture = 1'b1;
                    st_nxt  = SEQ_ISSUE;
                end
            end
            SEQ_ISSUE: begin
                if (rsp_vld) begin
                    if (rsp_code == RSP_RETRY) begin
                        wait_load = 1'b1;
                        st_nxt    = SEQ_BACKOFF;
                    end else begin
                        finish = 1'b1;
                        st_nxt = SEQ_IDLE;
                    end
                end
            end
            SEQ_BACKOFF: begin
                if (wait_expire) st_nxt = SEQ_ISSUE;
            end
            default: st_nxt = SEQ_IDLE;
        endcase
    end

    // Sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SEQ_IDLE;
        else        st_q <= st_nxt;
    end

    // Completion pulse, error flag and read data toward upstream
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            rdat_q <= '0;
        end else begin
            done_q <= finish;
            err_q  <= finish && code_is_error(rsp_code);
            if (finish) rdat_q <= rsp_rdat;
        end
    end

    assign up_rdy  = (st_q == SEQ_IDLE);
    assign cmd_vld = (st_q == SEQ_ISSUE);
    assign up_done = done_q;
    assign up_err  = err_q;
    assign up_rdat = rdat_q;

endmodule

// File: rtl/retry_master_chk.sv
// Property checker for retry_master, attached by bind.
// Observes ports and the generator state only.
module retry_master_chk #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int SEL_W     = DATA_W / 8,
    parameter int WAIT_BITS = 5,
    parameter int LFSR_W    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_rdy,
    input logic              up_done,
    input logic              up_err,
    input logic              cmd_vld,
    input logic [ADDR_W-1:0] cmd_adr,
    input logic              cmd_virt,
    input logic              cmd_we,
    input logic [SEL_W-1:0]  cmd_sel,
    input logic [DATA_W-1:0] cmd_wdat,
    input logic              rsp_vld,
    input logic [1:0]        rsp_code,
    input logic [LFSR_W-1:0] lfsr_val
);

    localparam int MAX_WAIT = 1 << WAIT_BITS;
    localparam int GAP_W    = WAIT_BITS + 2;

    logic [GAP_W-1:0] gap_q;

    // Length of the current backoff gap (busy with no command presented)
    always_ff @(posedge clk) begin
        if (!rst_n)                           gap_q <= '0;
        else if (!up_rdy && !cmd_vld && gap_q != '1) gap_q <= gap_q + 1'b1;
        else if (up_rdy || cmd_vld)           gap_q <= '0;
    end

    // R2
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_rdy && cmd_vld));

    // R3
    fields_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_rdy |=> ($stable(cmd_adr) && $stable(cmd_virt) && $stable(cmd_we) && $stable(cmd_wdat)));

    // R4
    sel_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_rdy |=> $stable(cmd_sel));

    // R5
    cmd_until_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && !rsp_vld) |=> cmd_vld);

    // R6
    retry_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && rsp_vld && rsp_code == 2'b01) |=> (!cmd_vld && !up_done && !up_rdy));

    // R7
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= GAP_W'(MAX_WAIT));

    // R8
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_val != '0);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_done |=> !up_done);

    // R10
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_err |-> up_done);

    // R11
    stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld |=> !up_done);

endmodule

bind retry_master retry_master_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SEL_W     (SEL_W),
    .WAIT_BITS (WAIT_BITS),
    .LFSR_W    (LFSR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_rdy   (up_rdy),
    .up_done  (up_done),
    .up_err   (up_err),
    .cmd_vld  (cmd_vld),
    .cmd_adr  (cmd_adr),
    .cmd_virt (cmd_virt),
    .cmd_we   (cmd_we),
    .cmd_sel  (cmd_sel),
    .cmd_wdat (cmd_wdat),
    .rsp_vld  (rsp_vld),
    .rsp_code (rsp_code),
    .lfsr_val (lfsr_val)
);

// File: tb/retry_master_bench.sv
// Bench for retry_master: a behavioural reference model compared every cycle,
// plus a directed run on a second instance built in fixed-wait mode.
module retry_master_bench;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Random-mode instance signals
    logic          up_req = 0, up_virt = 0, up_we = 0;
    logic [AW-1:0] up_adr = 0;
    logic [SW-1:0] up_sel = 0;
    logic [DW-1:0] up_wdat = 0;
    logic          up_rdy, up_done, up_err, cmd_vld, cmd_virt, cmd_we;
    logic [DW-1:0] up_rdat, cmd_wdat;
    logic [AW-1:0] cmd_adr;
    logic [SW-1:0] cmd_sel;
    logic          rsp_vld = 0;
    logic [1:0]    rsp_code = 0;
    logic [DW-1:0] rsp_rdat = 0;

    // Fixed-mode instance signals
    logic          f_req = 0, f_rsp_vld = 0;
    logic [1:0]    f_rsp_code = 0;
    logic          f_rdy, f_done, f_err, f_cmd_vld, f_cmd_virt, f_cmd_we;
    logic [DW-1:0] f_rdat, f_cmd_wdat;
    logic [AW-1:0] f_cmd_adr;
    logic [SW-1:0] f_cmd_sel;

    retry_master u_retry_master (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_rdy(up_rdy),
        .up_adr(up_adr), .up_virt(up_virt), .up_we(up_we), .up_sel(up_sel),
        .up_wdat(up_wdat), .up_done(up_done), .up_err(up_err), .up_rdat(up_rdat),
        .cmd_vld(cmd_vld), .cmd_adr(cmd_adr), .cmd_virt(cmd_virt), .cmd_we(cmd_we),
        .cmd_sel(cmd_sel), .cmd_wdat(cmd_wdat), .rsp_vld(rsp_vld),
        .rsp_code(rsp_code), .rsp_rdat(rsp_rdat)
    );

    retry_master #(.FIXED_WAIT(1'b1)) u_retry_master_fixed (
        .clk(clk), .rst_n(rst_n), .up_req(f_req), .up_rdy(f_rdy),
        .up_adr(32'h0000_4000), .up_virt(1'b1), .up_we(1'b1), .up_sel(4'b1010),
        .up_wdat(32'h5A5A_0001), .up_done(f_done), .up_err(f_err), .up_rdat(f_rdat),
        .cmd_vld(f_cmd_vld), .cmd_adr(f_cmd_adr), .cmd_virt(f_cmd_virt), .cmd_we(f_cmd_we),
        .cmd_sel(f_cmd_sel), .cmd_wdat(f_cmd_wdat), .rsp_vld(f_rsp_vld),
        .rsp_code(f_rsp_code), .rsp_rdat(32'h0)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model (behavioural), updated on each rising edge
    int            m_st = 0;  // 0 idle, 1 presenting, 2 waiting
    int            m_cnt = 0;
    int            m_lf = 16'hACE1;
    logic [AW-1:0] m_adr = 0;
    logic          m_virt = 0, m_we = 0, m_done = 0, m_err = 0;
    logic [SW-1:0] m_sel = 0;
    logic [DW-1:0] m_wdat = 0, m_rdat = 0;
    bit            started = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_lf = 16'hACE1;
            m_adr = 0; m_virt = 0; m_we = 0; m_sel = 0; m_wdat = 0;
            m_done = 0; m_err = 0; m_rdat = 0;
        end else begin
            started = 1;
            m_done = 0; m_err = 0;
            if (m_st == 0) begin
                if (up_req) begin
                    m_adr = up_adr; m_virt = up_virt; m_we = up_we;
                    m_sel = up_sel; m_wdat = up_wdat; m_st = 1;
                end
            end else if (m_st == 1) begin
                if (rsp_vld) begin
                    if (rsp_code == 2'b01) begin
                        m_cnt = (m_lf % 32) + 1;  // R7
                        m_st = 2;
                    end else begin
                        m_done = 1; m_err = (rsp_code != 2'b00);
                        m_rdat = rsp_rdat; m_st = 0;
                    end
                end
            end else begin
                if (m_cnt == 1) m_st = 1;
                m_cnt = m_cnt - 1;
            end
            // R8: shift left, new bit = b15^b13^b12^b10
            m_lf = ((m_lf << 1) & 16'hFFFF)
                 | (((m_lf >> 15) ^ (m_lf >> 13) ^ (m_lf >> 12) ^ (m_lf >> 10)) & 1);
        end
    end

    // Slave model: answers from a queue after a latency; optional stray responses
    logic [1:0] code_q[$];
    int         slv_lat = 0;
    int         slv_wait = 0;
    bit         stray_en = 0;

    always @(negedge clk) begin
        rsp_vld <= 1'b0;
        if (rst_n && cmd_vld) begin
            if (slv_wait >= slv_lat && code_q.size() > 0) begin
                rsp_vld  <= 1'b1;
                rsp_code <= code_q.pop_front();
                rsp_rdat <= $urandom;
                slv_wait = 0;
            end else begin
                slv_wait++;
            end
        end else begin
            slv_wait = 0;
            if (stray_en) begin
                rsp_vld  <= 1'b1;
                rsp_code <= 2'b00;
                rsp_rdat <= $urandom;
            end
        end
    end

    // Per-cycle comparison and measurement of backoff gaps
    int  gap = 0;
    bit  in_gap = 0;
    bit  prev_vld = 0;
    int  gap_min = 1000, gap_max = 0, gap_n = 0;
    bit  gap_seen[int];

    always @(negedge clk) begin
        if (started && rst_n) begin
            chk("R2", "up_rdy", up_rdy, m_st == 0);
            chk("R5", "cmd_vld", cmd_vld, m_st == 1);
            chk("R3", "cmd_adr", cmd_adr, m_adr);
            chk("R3", "cmd_virt", cmd_virt, m_virt);
            chk("R3", "cmd_we", cmd_we, m_we);
            chk("R3", "cmd_wdat", cmd_wdat, m_wdat);
            chk("R4", "cmd_sel", cmd_sel, m_sel);
            chk("R10", "up_done", up_done, m_done);
            chk("R10", "up_err", up_err, m_err);
            if (m_done) chk("R10", "up_rdat", up_rdat, m_rdat);
            // R6 gap measured from the ports
            if (prev_vld && !cmd_vld && !up_rdy) begin in_gap = 1; gap = 0; end
            if (in_gap) begin
                if (cmd_vld) begin
                    in_gap = 0;
                    gap_n++;
                    gap_seen[gap] = 1;
                    if (gap < gap_min) gap_min = gap;
                    if (gap > gap_max) gap_max = gap;
                end else gap++;
            end
            prev_vld = cmd_vld;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // One transaction on the random-mode instance
    task automatic run_txn(input logic [AW-1:0] adr, input logic virt, input logic we,
                           input logic [SW-1:0] sel, input logic [DW-1:0] wdat,
                           input int nretry, input logic [1:0] last, input int lat,
                           input bit hold_req);
        slv_lat = lat;
        for (int i = 0; i < nretry; i++) code_q.push_back(2'b01);
        code_q.push_back(last);
        while (!up_rdy) @(negedge clk);
        up_req = 1; up_adr = adr; up_virt = virt; up_we = we; up_sel = sel; up_wdat = wdat;
        @(negedge clk);
        if (!hold_req) up_req = 0;
        while (!up_done) begin
            if (hold_req) begin
                up_adr = $urandom; up_sel = $urandom; up_wdat = $urandom;
                up_virt = ~up_virt; up_we = ~up_we;
            end
            @(negedge clk);
        end
        up_req = 0;
        @(negedge clk);
    endtask

    int f_gap;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "up_rdy after reset", up_rdy, 1);
        chk("R1", "cmd_vld after reset", cmd_vld, 0);
        chk("R1", "up_done after reset", up_done, 0);

        // R5 R10: plain ack, no retry
        run_txn(32'h1000_0000, 1'b1, 1'b0, 4'b1111, 32'h0, 0, 2'b00, 0, 0);
        // R6 R7: retries then ack, slow slave
        run_txn(32'h2000_0040, 1'b0, 1'b1, 4'b0011, 32'hDEAD_BEEF, 3, 2'b00, 2, 0);
        // R10: retries then error code 2'b10
        run_txn(32'h3000_0080, 1'b1, 1'b1, 4'b1000, 32'h1234_5678, 2, 2'b10, 1, 0);
        // R5 R10: code 2'b11 is an error
        run_txn(32'h3000_00C0, 1'b0, 1'b0, 4'b0100, 32'h0, 1, 2'b11, 0, 0);
        // R2 R3 R4: upstream keeps requesting with changing fields
        run_txn(32'h4000_0100, 1'b1, 1'b1, 4'b0110, 32'hCAFE_0000, 4, 2'b00, 1, 1);
        // R11: stray responses in idle and during backoff
        stray_en = 1;
        repeat (10) @(negedge clk);
        chk("R11", "no done from idle stray", up_done, 0);
        run_txn(32'h5000_0140, 1'b0, 1'b1, 4'b1001, 32'hFEED_0001, 5, 2'b00, 0, 0);
        stray_en = 0;
        // R7 R8: many random transactions
        for (int t = 0; t < 20; t++)
            run_txn($urandom, 1'($urandom), 1'($urandom), SW'($urandom), $urandom,
                    int'($urandom % 5), (($urandom % 4) == 0) ? 2'b10 : 2'b00,
                    int'($urandom % 3), 1'($urandom));
        chk("R7", "gap minimum >= 1", gap_min >= 1, 1);
        chk("R7", "gap maximum <= 32", gap_max <= 32, 1);
        chk("R8", "wait draws vary", gap_seen.num() > 3, 1);
        chk("R6", "gaps measured", gap_n > 20, 1);

        // R9: fixed-mode instance, two retries then ack
        @(negedge clk);
        f_req = 1;
        @(negedge clk);
        f_req = 0;
        for (int r = 0; r < 2; r++) begin
            chk("R9", "fixed cmd_vld before retry", f_cmd_vld, 1);
            f_rsp_vld = 1; f_rsp_code = 2'b01;
            @(negedge clk);
            f_rsp_vld = 0;
            f_gap = 0;
            while (!f_cmd_vld && f_gap < 100) begin
                f_gap++;
                chk("R4", "fixed sel held in wait", f_cmd_sel, 4'b1010);
                @(negedge clk);
            end
            chk("R9", "fixed wait length", f_gap, 32);
            chk("R6", "fixed no done on retry", f_done, 0);
        end
        f_rsp_vld = 1; f_rsp_code = 2'b00;
        @(negedge clk);
        f_rsp_vld = 0;
        chk("R9", "fixed done", f_done, 1);
        chk("R9", "fixed err", f_err, 0);
        chk("R4", "fixed sel at end", f_cmd_sel, 4'b1010);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule